// File: doc/BRIEF.md
# Cascadable presettable synchronous binary counter

This block is a synchronous binary up-counter whose width is a parameter (4 bits by default). An active-low clear zeroes the count at once, without waiting for a clock edge. An active-low load copies a parallel data word into the count on the rising edge of the clock. Counting needs two active-high enables, called P and T, to be high together.

A ripple carry output is the AND of enable T with every count bit. Because of this, several instances can be chained into one wider synchronous counter. Each stage's carry drives the next stage's enable T, and all stages share the clock, the clear, the load and enable P. Enable P pauses the whole chain without changing any carry. Enable T also qualifies the carry combinationally, so the carry chain works as a lookahead.

Top module: `bincnt_preset`

## Requirements
- R1: While clr_n is low, cnt is 0 with no clock edge needed. This overrides load_n, en_p, en_t and data.
- R2: With clr_n high and load_n low, a rising clk edge copies data into cnt, whatever the values of en_p and en_t.
- R3: With clr_n and load_n high, a rising clk edge adds one to cnt when en_p and en_t are both 1.
- R4: With clr_n and load_n high, cnt keeps its value across a rising clk edge when en_p is 0 or en_t is 0.
- R5: carry is 1 exactly when en_t is 1 and every bit of cnt is 1. It follows a change on en_t without a clock edge.
- R6: cnt is plain binary and wraps from all ones to 0 on a counting edge.
- R7: While clr_n is low, carry is 0.
- R8: load_n, en_p and en_t act only through their value at the rising clk edge. A load pulse that ends before the edge leaves cnt unchanged.
- R9: Three 4-bit stages can be chained, stage k's carry driving stage k+1's en_t, with stage 0's en_t held at 1. The value {stage2,stage1,stage0} then steps through all 4096 values in order and wraps to 0. The last stage's carry is 1 only at 0xFFF. With en_p at 0 the whole chain holds.
- R10: At a non-default WIDTH of 6, carry is 1 only at count 63 with en_t at 1, and the next counting edge wraps the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| data | input | WIDTH | Parallel word to load |
| cnt | output | WIDTH | Present count |
| carry | output | 1 | Ripple carry: en_t AND all count bits |

## Verification
The clocked properties assume that load_n, en_p, en_t and data are known and steady around each rising edge. They also assume clr_n is released away from an edge. The stimulus therefore changes inputs only at the falling edge, or partway through the low half of the clock, and releases clear on a falling edge. Mid-cycle changes happen only on purpose: a glitching load pulse, an en_t toggle and an asynchronous clear. Each is placed well clear of the rising edge, so that what the block does is decided by its asynchronous or combinational paths.

// File: rtl/bincnt_pkg.sv
`timescale 1ns/1ps
package bincnt_pkg;

    // Action taken by the count register at the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/bincnt_ctl.sv
`timescale 1ns/1ps
module bincnt_ctl
    import bincnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // Load wins over counting; counting needs both enables
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/bincnt_carry.sv
`timescale 1ns/1ps
module bincnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_t,
    output logic             carry
);

    localparam int CHAIN = WIDTH + 1;

    // Serial AND chain seeded by the enable, one link per count bit
    logic [CHAIN-1:0] link;

    assign link[0] = en_t;

    for (genvar i = 0; i < WIDTH; i++) begin : g_link
        assign link[i+1] = link[i] & cnt[i];
    end

    assign carry = link[CHAIN-1];

endmodule

// File: rtl/bincnt_reg.sv
`timescale 1ns/1ps
module bincnt_reg
    import bincnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] cnt
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.cnt = data;
            OP_COUNT: st_d.cnt = st_q.cnt + STEP;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R1
    always @(negedge clk) begin
        if (clr_n === 1'b0) begin
            clear_zero_chk: assert (st_q.cnt == '0);
        end
    end

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (st_q.cnt == $past(data)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_COUNT) |=> (st_q.cnt == $past(st_q.cnt) + STEP));

    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> $stable(st_q.cnt));

endmodule

// File: rtl/bincnt_preset.sv
`timescale 1ns/1ps
module bincnt_preset
    import bincnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] cnt,
    output logic             carry
);

    cnt_op_e op;

    bincnt_ctl u_ctl (
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    bincnt_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .data  (data),
        .cnt   (cnt)
    );

    bincnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cnt   (cnt),
        .en_t  (en_t),
        .carry (carry)
    );

    // R7
    always @(negedge clk) begin
        if (clr_n === 1'b0) begin
            clear_carry_chk: assert (carry == 1'b0);
        end
    end

    // R5
    carry_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (cnt == '1));

    // R5
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !carry);

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (carry && en_p && load_n) |=> (cnt == '0));

endmodule

// File: tb/bincnt_preset_bench.sv
`timescale 1ns/1ps
module bincnt_preset_bench;

    localparam real HALF = 2.0;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] data = 4'h0;
    logic [3:0] cnt;
    logic       carry;

    int n_checks = 0;
    int n_fail = 0;

    always #(HALF) clk = ~clk;

    bincnt_preset #(.WIDTH(4)) u_bincnt_preset (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .data(data), .cnt(cnt), .carry(carry)
    );

    // Three-stage cascade
    logic        c_load_n = 1'b1;
    logic        c_en_p = 1'b0;
    logic [3:0] c_q0, c_q1, c_q2;
    logic        c_co0, c_co1, c_co2;

    bincnt_preset #(.WIDTH(4)) u_s0 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .en_p(c_en_p), .en_t(1'b1),
        .data(4'h0), .cnt(c_q0), .carry(c_co0)
    );
    bincnt_preset #(.WIDTH(4)) u_s1 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .en_p(c_en_p), .en_t(c_co0),
        .data(4'h0), .cnt(c_q1), .carry(c_co1)
    );
    bincnt_preset #(.WIDTH(4)) u_s2 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .en_p(c_en_p), .en_t(c_co1),
        .data(4'h0), .cnt(c_q2), .carry(c_co2)
    );

    // Six-bit instance
    logic       w_load_n = 1'b1;
    logic       w_en = 1'b0;
    logic [5:0] w_data = 6'd0;
    logic [5:0] w_q;
    logic       w_co;

    bincnt_preset #(.WIDTH(6)) u_w6 (
        .clk(clk), .clr_n(clr_n), .load_n(w_load_n), .en_p(w_en), .en_t(w_en),
        .data(w_data), .cnt(w_q), .carry(w_co)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct {
        logic [3:0] cnt;
        logic       carry;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [3:0] m_cnt = 4'h0;

    // Called at a falling edge; result is due after the next rising edge
    task automatic drive(input logic ld_n, input logic ep, input logic et,
                         input logic [3:0] d, input string tag);
        exp_t e;
        load_n = ld_n; en_p = ep; en_t = et; data = d;
        if (!ld_n) m_cnt = d;
        else if (ep && et) m_cnt = m_cnt + 4'd1;
        e.cnt = m_cnt;
        e.carry = et && (m_cnt == 4'hF);
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check({e.tag, " cnt"}, 32'(cnt), 32'(e.cnt));
                check({e.tag, " carry"}, 32'(carry), 32'(e.carry));
            end
        end
    end

    initial begin : watchdog
        #(4.0 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [11:0] c_exp;
        load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; data = 4'hA;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset cnt", 32'(cnt), 32'h0);
        check("R7 reset carry", 32'(carry), 32'h0);
        check("R9 reset cascade", 32'({c_q2, c_q1, c_q0}), 32'h0);
        @(negedge clk);
        load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
        clr_n = 1'b1;
        @(negedge clk);
        m_cnt = 4'h0;

        drive(1'b0, 1'b0, 1'b0, 4'h5, "R2 load enables low");
        drive(1'b0, 1'b1, 1'b1, 4'hE, "R2 load enables high");
        drive(1'b1, 1'b1, 1'b1, 4'h0, "R3 count to F");
        drive(1'b1, 1'b1, 1'b1, 4'h0, "R6 wrap to 0");
        drive(1'b1, 1'b0, 1'b1, 4'h7, "R4 hold en_p low");
        drive(1'b1, 1'b1, 1'b0, 4'h7, "R4 hold en_t low");
        drive(1'b1, 1'b1, 1'b1, 4'h0, "R3 count to 1");
        drive(1'b1, 1'b1, 1'b1, 4'h0, "R3 count to 2");
        drive(1'b0, 1'b0, 1'b0, 4'hF, "R2 load F");
        drive(1'b1, 1'b0, 1'b0, 4'h0, "R4 hold F");

        // R5: carry follows en_t with no clock edge (en_p low, count F)
        #0.5 en_t = 1'b1;
        #0.5 check("R5 carry rises with en_t", 32'(carry), 32'h1);
        en_t = 1'b0;
        #0.5 check("R5 carry falls with en_t", 32'(carry), 32'h0);
        @(negedge clk);

        // R8: load pulse ending before the edge
        load_n = 1'b0; data = 4'h3;
        #0.5 load_n = 1'b1;
        @(posedge clk);
        #1 check("R8 short load ignored", 32'(cnt), 32'hF);
        @(negedge clk);

        // R1/R7: asynchronous clear overriding load and count
        load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; data = 4'h9;
        #0.5 clr_n = 1'b0;
        #0.5 check("R1 async clear cnt", 32'(cnt), 32'h0);
        check("R7 async clear carry", 32'(carry), 32'h0);
        @(posedge clk);
        #1 check("R1 clear overrides load", 32'(cnt), 32'h0);
        @(negedge clk);
        load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
        clr_n = 1'b1;
        m_cnt = 4'h0;
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 4'h0, "R3 count after clear");

        // R9: cascade through every value
        c_exp = 12'h000;
        c_en_p = 1'b1;
        for (int i = 0; i < 4096; i++) begin
            @(posedge clk);
            #1;
            c_exp = c_exp + 12'd1;
            check("R9 cascade value", 32'({c_q2, c_q1, c_q0}), 32'(c_exp));
            check("R9 top carry", 32'(c_co2), 32'(c_exp == 12'hFFF));
        end
        @(negedge clk);
        c_en_p = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R9 cascade stall", 32'({c_q2, c_q1, c_q0}), 32'(c_exp));
        @(negedge clk);

        // R10: six-bit width
        w_load_n = 1'b0; w_data = 6'd62;
        @(negedge clk);
        w_load_n = 1'b1;
        check("R10 load 62", 32'(w_q), 32'd62);
        check("R10 no carry at 62", 32'(w_co), 32'h0);
        w_en = 1'b1;
        @(posedge clk);
        #1 check("R10 count 63", 32'(w_q), 32'd63);
        check("R10 carry at 63", 32'(w_co), 32'h1);
        @(posedge clk);
        #1 check("R10 wrap to 0", 32'(w_q), 32'd0);
        check("R10 carry after wrap", 32'(w_co), 32'h0);
        @(negedge clk);
        w_en = 1'b0;

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule